// File: doc/BRIEF.md
# Working Register File with Pointer Address Unit

This block holds the thirty-two 8-bit working registers of a small processor core. Two combinational read ports and one clocked write port let a single ALU operation fetch two operands and store its result in the same clock. The three highest register pairs also act as 16-bit data pointers. An address unit builds an effective data-space address from one of these pointers in one of four modes: plain indirect, post-increment, pre-decrement, or pointer plus an unsigned displacement. In the increment and decrement modes it writes the updated pointer back into its register pair.

Each effective address is then sorted into one of three regions of the data space. The lowest addresses alias the register file itself. The next window holds I/O registers. Everything above that goes to SRAM. The block drives only the address, the region select and a local index within the region. The SRAM array, the I/O peripherals and instruction decoding sit outside it.

An access request enters as a valid/ready stream and leaves as the effective-address stream. The request is taken, and any pointer update is committed, only in a cycle where both `acc_valid` and `ea_ready` are high. While `ea_ready` is low the request must be held. The address output then stays steady, and no pointer changes.

Top module: `regfile_ptr_unit`

## Requirements
- R1: After reset every one of the 32 registers reads 0x00.
- R2: The read ports A and B return the addressed registers combinationally and independently. A write with `wr_en` high becomes visible on the read ports only after the next rising clock edge.
- R3: Pointer select code 0 picks pointer X, made of registers 27 (high byte) and 26 (low byte). Code 1 picks Y, made of registers 29 and 28. Code 2 picks Z, made of registers 31 and 30. Reserved code 3 also selects Z.
- R4: Mode code 0 (plain) outputs the pointer as the address and leaves the pointer unchanged.
- R5: Mode code 1 (post-increment) outputs the current pointer as the address. On acceptance it writes back pointer+1 modulo 2^16, so 0xFFFF becomes 0x0000.
- R6: Mode code 2 (pre-decrement) outputs pointer-1 modulo 2^16 as the address. On acceptance it writes that same value back, so 0x0000 gives address 0xFFFF.
- R7: Mode code 3 (displacement) on Y or Z outputs pointer + q, where q is `acc_disp` read as an unsigned 6-bit value, and the sum wraps modulo 2^16. The pointer is left unchanged. Mode code 3 on X behaves as plain mode.
- R8: Region decoding works as follows:
  - Addresses 0x0000–0x001F set `ea_in_rf`, with `ea_rf_idx` equal to the address.
  - Addresses 0x0020–0x005F set `ea_in_io`, with `ea_io_idx` equal to the address minus 0x20.
  - All higher addresses set `ea_in_sram`.
  - Exactly one select is high, and an index outside its region reads 0.
- R9: `ea_valid` follows `acc_valid` and `acc_ready` follows `ea_ready`. With `ea_ready` low, no pointer changes and the address output stays stable.
- R10: When a pointer write-back and the write port target the same register in one cycle, the pointer value wins. A port write to any other register in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 5 | Write port register index |
| wr_data | input | 8 | Write port data |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted this cycle |
| acc_ptr | input | 2 | Pointer select (0 X, 1 Y, 2/3 Z) |
| acc_mode | input | 2 | Mode (0 plain, 1 post-inc, 2 pre-dec, 3 displacement) |
| acc_disp | input | 6 | Unsigned displacement q |
| ea_valid | output | 1 | Effective address valid |
| ea_ready | input | 1 | Downstream ready for the address |
| ea_addr | output | 16 | Effective data-space address |
| ea_in_rf | output | 1 | Address falls in the register-file alias |
| ea_in_io | output | 1 | Address falls in the I/O window |
| ea_in_sram | output | 1 | Address falls in SRAM |
| ea_rf_idx | output | 5 | Register index when in the register-file alias |
| ea_io_idx | output | 6 | I/O index when in the I/O window |

## Verification
The address unit is exercised with each mode on each pointer, starting from values that sit at a wrap point (0xFFFF for increment, 0x0000 for decrement, 0xFFF0 with a large displacement). These show whether the write-back and the effective address use modulo arithmetic and whether each uses the old or the new pointer value. Plain accesses at 0x1F, 0x20, 0x5F and 0x60 separate the three regions at both edges of the I/O window, where an off-by-one would move a single address across. Stalled requests, same-cycle write-port collisions and displacement requests on X test whether the pointer moves only under the right handshake, with the right priority and in the right mode.

// File: rtl/regfile_ptr_pkg.sv
package regfile_ptr_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_POSTINC = 2'd1,
    MODE_PREDEC  = 2'd2,
    MODE_DISP    = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    PSEL_X    = 2'd0,
    PSEL_Y    = 2'd1,
    PSEL_Z    = 2'd2,
    PSEL_RSVD = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/rfp_regs.sv
// Register storage: two combinational read ports, one write port and a
// pair-wide pointer write-back that overrides the write port (R10).
module rfp_regs #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_a_idx,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic [DATA_W-1:0]   rd_b_data,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                pw_en,
  input  logic [IDX_W-1:0]    pw_lo_idx,
  input  logic [2*DATA_W-1:0] pw_data,
  output logic [DATA_W-1:0]   regs_q [NUM_REGS]
);
  logic [IDX_W-1:0] pw_hi_idx;
  assign pw_hi_idx = pw_lo_idx + IDX_W'(1);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (pw_en && pw_lo_idx == IDX_W'(gi))
        q <= pw_data[DATA_W-1:0];
      else if (pw_en && pw_hi_idx == IDX_W'(gi))
        q <= pw_data[2*DATA_W-1:DATA_W];
      else if (wr_en && wr_idx == IDX_W'(gi))
        q <= wr_data;
    end
    assign regs_q[gi] = q;
  end

  assign rd_a_data = regs_q[rd_a_idx];
  assign rd_b_data = regs_q[rd_b_idx];
endmodule

// File: rtl/rfp_agen.sv
// Effective address and pointer update for one selected pointer.
module rfp_agen
  import regfile_ptr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DISP_W = 6
) (
  input  logic [PTR_W-1:0]  ptr_val,
  input  addr_mode_e        mode,
  input  logic              disp_ok,
  input  logic [DISP_W-1:0] disp,
  output logic [PTR_W-1:0]  ea,
  output logic [PTR_W-1:0]  ptr_next,
  output logic              ptr_upd
);
  always_comb begin
    ea       = ptr_val;
    ptr_next = ptr_val;
    ptr_upd  = 1'b0;
    unique case (mode)
      MODE_POSTINC: begin
        ptr_next = ptr_val + PTR_W'(1);
        ptr_upd  = 1'b1;
      end
      MODE_PREDEC: begin
        ptr_next = ptr_val - PTR_W'(1);
        ea       = ptr_next;
        ptr_upd  = 1'b1;
      end
      MODE_DISP: begin
        if (disp_ok) ea = ptr_val + PTR_W'(disp);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rfp_decode.sv
// Data-space region decoder: register alias, I/O window, SRAM.
module rfp_decode #(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int IO_SIZE  = 64,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int IO_W    = $clog2(IO_SIZE),
  localparam int IO_END  = NUM_REGS + IO_SIZE
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_rf,
  output logic              in_io,
  output logic              in_sram,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [IO_W-1:0]   io_idx
);
  always_comb begin
    in_rf   = addr < ADDR_W'(NUM_REGS);
    in_io   = !in_rf && (addr < ADDR_W'(IO_END));
    in_sram = !in_rf && !in_io;
    rf_idx  = in_rf ? addr[IDX_W-1:0] : '0;
    io_idx  = in_io ? IO_W'(addr - ADDR_W'(NUM_REGS)) : '0;
  end
endmodule

// File: rtl/regfile_ptr_unit.sv
// Top: register file, pointer address unit and data-space decoder.
// NUM_REGS must be at least 6; the top six registers form X, Y, Z.
module regfile_ptr_unit
  import regfile_ptr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int DISP_W   = 6,
  parameter int IO_SIZE  = 64,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int PTR_W   = 2 * DATA_W,
  localparam int IO_W    = $clog2(IO_SIZE),
  localparam int PTR_BASE = NUM_REGS - 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [1:0]        acc_ptr,
  input  logic [1:0]        acc_mode,
  input  logic [DISP_W-1:0] acc_disp,
  output logic              ea_valid,
  input  logic              ea_ready,
  output logic [PTR_W-1:0]  ea_addr,
  output logic              ea_in_rf,
  output logic              ea_in_io,
  output logic              ea_in_sram,
  output logic [IDX_W-1:0]  ea_rf_idx,
  output logic [IO_W-1:0]   ea_io_idx
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [IDX_W-1:0]  sel_lo;
  logic [PTR_W-1:0]  cur_ptr, ptr_next;
  logic              ptr_upd, acc_fire, disp_ok;
  logic [PTR_W-1:0]  ptr_x, ptr_y, ptr_z;

  always_comb begin
    unique case (ptr_sel_e'(acc_ptr))
      PSEL_X:  sel_lo = IDX_W'(PTR_BASE);
      PSEL_Y:  sel_lo = IDX_W'(PTR_BASE + 2);
      default: sel_lo = IDX_W'(PTR_BASE + 4);
    endcase
  end

  assign ptr_x   = {regs_q[PTR_BASE + 1], regs_q[PTR_BASE]};
  assign ptr_y   = {regs_q[PTR_BASE + 3], regs_q[PTR_BASE + 2]};
  assign ptr_z   = {regs_q[PTR_BASE + 5], regs_q[PTR_BASE + 4]};
  assign cur_ptr = {regs_q[sel_lo + IDX_W'(1)], regs_q[sel_lo]};
  assign disp_ok = (ptr_sel_e'(acc_ptr) != PSEL_X);

  assign acc_ready = ea_ready;
  assign ea_valid  = acc_valid;
  assign acc_fire  = acc_valid && ea_ready;

  rfp_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .pw_en     (acc_fire && ptr_upd),
    .pw_lo_idx (sel_lo),
    .pw_data   (ptr_next),
    .regs_q    (regs_q)
  );

  rfp_agen #(.PTR_W(PTR_W), .DISP_W(DISP_W)) u_agen (
    .ptr_val  (cur_ptr),
    .mode     (addr_mode_e'(acc_mode)),
    .disp_ok  (disp_ok),
    .disp     (acc_disp),
    .ea       (ea_addr),
    .ptr_next (ptr_next),
    .ptr_upd  (ptr_upd)
  );

  rfp_decode #(.ADDR_W(PTR_W), .NUM_REGS(NUM_REGS), .IO_SIZE(IO_SIZE)) u_dec (
    .addr    (ea_addr),
    .in_rf   (ea_in_rf),
    .in_io   (ea_in_io),
    .in_sram (ea_in_sram),
    .rf_idx  (ea_rf_idx),
    .io_idx  (ea_io_idx)
  );
endmodule

// File: rtl/regfile_ptr_unit_chk.sv
module regfile_ptr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        acc_valid,
  input logic        ea_ready,
  input logic [1:0]  acc_ptr,
  input logic [1:0]  acc_mode,
  input logic        ea_valid,
  input logic [15:0] ea_addr,
  input logic        ea_in_rf,
  input logic        ea_in_io,
  input logic        ea_in_sram,
  input logic [4:0]  ea_rf_idx,
  input logic [15:0] ptr_x,
  input logic [15:0] ptr_y,
  input logic [15:0] ptr_z
);
  logic fire;
  assign fire = acc_valid && ea_ready;

  // R8
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> $countones({ea_in_rf, ea_in_io, ea_in_sram}) == 1);

  // R8
  rf_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && ea_addr < 16'h0020) |-> (ea_in_rf && ea_rf_idx == ea_addr[4:0]));

  // R5
  postinc_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_mode == 2'd1 && acc_ptr == 2'd0 && !wr_en) |=> ptr_x == $past(ea_addr) + 16'd1);

  // R6
  predec_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_mode == 2'd2 && acc_ptr == 2'd1 && !wr_en) |=> ptr_y == $past(ea_addr));

  // R7
  disp_z_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_mode == 2'd3 && acc_ptr[1] && !wr_en) |=> $stable(ptr_z));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !wr_en) |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));
endmodule

bind regfile_ptr_unit regfile_ptr_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .acc_valid  (acc_valid),
  .ea_ready   (ea_ready),
  .acc_ptr    (acc_ptr),
  .acc_mode   (acc_mode),
  .ea_valid   (ea_valid),
  .ea_addr    (ea_addr),
  .ea_in_rf   (ea_in_rf),
  .ea_in_io   (ea_in_io),
  .ea_in_sram (ea_in_sram),
  .ea_rf_idx  (ea_rf_idx),
  .ptr_x      (ptr_x),
  .ptr_y      (ptr_y),
  .ptr_z      (ptr_z)
);

// File: tb/tb_regfile_ptr_unit.sv
module tb_regfile_ptr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [7:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 1'b0, acc_valid = 1'b0, ea_ready = 1'b0;
  logic acc_ready, ea_valid;
  logic [1:0] acc_ptr = '0, acc_mode = '0;
  logic [5:0] acc_disp = '0;
  logic [15:0] ea_addr;
  logic ea_in_rf, ea_in_io, ea_in_sram;
  logic [4:0] ea_rf_idx;
  logic [5:0] ea_io_idx;

  always #10 clk = ~clk;

  regfile_ptr_unit dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_ptr(acc_ptr), .acc_mode(acc_mode), .acc_disp(acc_disp),
    .ea_valid(ea_valid), .ea_ready(ea_ready), .ea_addr(ea_addr),
    .ea_in_rf(ea_in_rf), .ea_in_io(ea_in_io), .ea_in_sram(ea_in_sram),
    .ea_rf_idx(ea_rf_idx), .ea_io_idx(ea_io_idx)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        rf, io, sram;
    logic [4:0]  ri;
    logic [5:0]  ii;
    logic [7:0]  tag;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] model [32];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic exp_t decode(input logic [15:0] a, input int tag);
    exp_t e;
    e.addr = a; e.tag = 8'(tag);
    e.rf = a < 16'h20; e.io = !e.rf && a < 16'h60; e.sram = !e.rf && !e.io;
    e.ri = e.rf ? a[4:0] : 5'd0;
    e.ii = e.io ? 6'(a - 16'h20) : 6'd0;
    return e;
  endfunction

  // Monitor: compare each accepted address against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk); #5;
      if (ea_valid && ea_ready) begin
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R9 actual=unexpected accept 0x%0h expected=none", ea_addr);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check($sformatf("R%0d ea_addr", e.tag), 32'(ea_addr), 32'(e.addr));
          check("R8 region selects", {29'd0, ea_in_rf, ea_in_io, ea_in_sram}, {29'd0, e.rf, e.io, e.sram});
          check("R8 region index", {21'd0, ea_rf_idx, ea_io_idx}, {21'd0, e.ri, e.ii});
          check("R9 acc_ready", 32'(acc_ready), 32'd1);
        end
      end
    end
  end

  task automatic write_reg(input int idx, input int val);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_data = 8'(val);
    rd_a_idx = 5'(idx); #5;
    check("R2 write not yet visible", 32'(rd_a_data), 32'(model[idx]));
    @(posedge clk); #1;
    wr_en = 0; model[idx] = 8'(val);
  endtask

  task automatic set_ptr(input int lo, input int val);
    write_reg(lo, val & 8'hFF);
    write_reg(lo + 1, (val >> 8) & 8'hFF);
  endtask

  task automatic read_chk(input string req, input int a, input int b);
    @(negedge clk);
    rd_a_idx = 5'(a); rd_b_idx = 5'(b); #5;
    check({req, " port A"}, 32'(rd_a_data), 32'(model[a]));
    check({req, " port B"}, 32'(rd_b_data), 32'(model[b]));
  endtask

  // Driver: compute expectation from the requirements, push it, drive.
  task automatic access(input int p, input int m, input int q, input int tag,
                        input bit wen = 0, input int widx = 0, input int wval = 0);
    int lo;
    logic [15:0] ptr, ea, nxt;
    bit upd;
    lo  = 26 + 2 * ((p == 3) ? 2 : p);
    ptr = {model[lo + 1], model[lo]};
    ea = ptr; nxt = ptr; upd = 0;
    case (m)
      1: begin nxt = ptr + 16'd1; upd = 1; end
      2: begin nxt = ptr - 16'd1; ea = nxt; upd = 1; end
      3: if (p != 0) ea = ptr + 16'(q);
      default: ;
    endcase
    exp_q.push_back(decode(ea, tag));
    @(negedge clk);
    acc_valid = 1; ea_ready = 1; acc_ptr = 2'(p); acc_mode = 2'(m); acc_disp = 6'(q);
    wr_en = wen; wr_idx = 5'(widx); wr_data = 8'(wval);
    @(posedge clk); #1;
    acc_valid = 0; ea_ready = 0; wr_en = 0;
    if (wen) model[widx] = 8'(wval);
    if (upd) begin model[lo] = nxt[7:0]; model[lo + 1] = nxt[15:8]; end
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: all registers zero after reset
    for (int i = 0; i < 32; i += 2) read_chk("R1 reset", i, i + 1);

    // R2: independent reads of written values
    write_reg(3, 8'hA5);
    write_reg(17, 8'h3C);
    read_chk("R2 read", 3, 17);
    read_chk("R2 read swapped", 17, 3);

    // R3/R4: plain X -> register alias
    set_ptr(26, 16'h0010);
    access(0, 0, 0, 4);
    read_chk("R4 X unchanged", 26, 27);
    // R5: post-increment twice
    access(0, 1, 0, 5);
    access(0, 1, 0, 5);
    read_chk("R5 X incremented", 26, 27);
    // R6: pre-decrement on Y into I/O window
    set_ptr(28, 16'h005F);
    access(1, 2, 0, 6);
    read_chk("R6 Y decremented", 28, 29);
    // R7: displacement on Z and Y, then on X (acts plain)
    set_ptr(30, 16'h0040);
    access(2, 3, 63, 7);
    access(1, 3, 0, 7);
    access(0, 3, 40, 7);
    read_chk("R7 Z unchanged", 30, 31);
    // R3: reserved select code maps to Z
    access(3, 3, 5, 3);
    // Wrap cases
    set_ptr(26, 16'hFFFF);
    access(0, 1, 0, 5);
    read_chk("R5 X wrap", 26, 27);
    set_ptr(28, 16'h0000);
    access(1, 2, 0, 6);
    read_chk("R6 Y wrap", 28, 29);
    set_ptr(30, 16'hFFF0);
    access(2, 3, 32, 7);
    // R8: region edges through plain Z
    set_ptr(30, 16'h001F); access(2, 0, 0, 8);
    set_ptr(30, 16'h0020); access(2, 0, 0, 8);
    set_ptr(30, 16'h005F); access(2, 0, 0, 8);
    set_ptr(30, 16'h0060); access(2, 0, 0, 8);

    // R9: stalled request holds address and leaves pointers alone
    set_ptr(26, 16'h1234);
    @(negedge clk);
    acc_valid = 1; ea_ready = 0; acc_ptr = 2'd0; acc_mode = 2'd1;
    #5;
    check("R9 ea_valid follows", 32'(ea_valid), 32'd1);
    check("R9 acc_ready low", 32'(acc_ready), 32'd0);
    check("R9 stall addr", 32'(ea_addr), 32'h1234);
    @(negedge clk); #5;
    check("R9 stall addr stable", 32'(ea_addr), 32'h1234);
    acc_valid = 0;
    read_chk("R9 X held", 26, 27);
    access(0, 1, 0, 9);
    read_chk("R9 X after accept", 26, 27);

    // R10: same-register conflict, then a different-register write
    access(0, 1, 0, 10, 1, 26, 8'hAA);
    read_chk("R10 pointer wins", 26, 27);
    access(0, 2, 0, 10, 1, 5, 8'h77);
    read_chk("R10 other write kept", 5, 26);

    repeat (2) @(negedge clk);
    check("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule